// File: doc/BRIEF.md
# Bitstream Header Ratio Selector

This block sits beside a 32-bit configuration data stream and inspects the header while the words pass through. Each word index is counted from the first word accepted after a start pulse. The block captures an encryption field and a compression bit at two fixed positions in the header. From these flags and the configuration width chosen at start, it works out how many clock cycles each data word needs, as an encoded ratio field. A loader sets up the configuration engine with this result before programming begins.

The stream is valid/ready. The block never applies back-pressure: ready is held high, so a word transfers on every cycle that valid is high. A word marked last before the header is complete means the stream is too short for a decision, and the block raises a length error instead of a done pulse. A run only counts words that arrive between a start pulse and the end of the header. Words before the first start, and words after the header, have no effect.

Top module: `hdr_ratio_sel`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during reset, so the stream is never stalled.
- R2: A `start` pulse clears the flags, the length error and the word counter, and arms a new run. If `start` and `in_valid` are both high in one cycle, that word is not counted.
- R3: Word indices start at 0 with the first word accepted after `start`. Only cycles with `in_valid` high advance the index. Words seen while no run is armed (after reset, before any start) have no effect.
- R4: `enc_flag` is 1 when bits [3:2] of word index 69 are nonzero, and 0 otherwise.
- R5: `cmp_flag` is 1 when bit 1 of word index 229 is 0. The bit is active-low.
- R6: `ratio_code` encodes x1=0, x2=1, x4=2, x8=3. With both flags clear it is 0 at either width. At 16-bit width it is 2 when compressed and 1 when encrypted but not compressed.
- R7: At 32-bit width (`wide_mode`=1) every non-x1 result is one code higher: compressed gives 3 and encrypted-only gives 2.
- R8: `done` is a one-cycle pulse in the cycle after word 229 is accepted. From that cycle until the next start or reset, the flags and `ratio_code` hold the final result.
- R9: If a word with `in_last`=1 is accepted at an index below 229, `len_err` becomes 1 and stays 1 until the next start or reset, and no `done` pulse follows.
- R10: Words after index 229 do not change the flags and do not raise `done` or `len_err` until the next start.
- R11: `wide_mode` is sampled only at `start`. Changing it later does not change the result.
- R12: Synchronous reset clears the flags, `ratio_code`, `done` and `len_err`, and disarms the block until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new header inspection |
| wide_mode | input | 1 | 1 = 32-bit configuration width, 0 = 16-bit; sampled at start |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream ready, always 1 |
| in_data | input | 32 | Stream word |
| in_last | input | 1 | Marks the final word of the stream |
| enc_flag | output | 1 | Stream is encrypted |
| cmp_flag | output | 1 | Stream is compressed |
| ratio_code | output | 2 | Encoded clock-to-data ratio |
| done | output | 1 | One-cycle pulse: header decision complete |
| len_err | output | 1 | Stream ended before word 229 |

## Verification
The ratio function is tried with all four combinations of the two flags at both widths. The encryption field is tried as 01, 10 and 11, so a check on only one of its two bits is exposed. Every word other than 69 and 229 carries the encryption bits set and the compression bit at its active value. An off-by-one index, a start word counted by mistake, or a late capture therefore shows up as a wrong flag or a misplaced done pulse. Streams of length 1, 229, 230 and 260 separate the error case from the exact-length case and from the ignored tail. Idle gaps, a mid-stream restart, pre-start words and a width change after start show that only accepted words in an armed run count, and that the width is latched.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/hrs_word_counter.sv
module hrs_word_counter #(
  parameter int LAST_IDX = 229,
  localparam int CNT_W = $clog2(LAST_IDX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  input  logic             in_last,
  output logic [CNT_W-1:0] idx,
  output logic             take,
  output logic             hit_end,
  output logic             short_end
);
  logic armed;

  assign take      = in_valid && armed && !start;
  assign hit_end   = take && (idx == CNT_W'(LAST_IDX));
  assign short_end = take && in_last && (idx != CNT_W'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      idx   <= '0;
    end else if (start) begin
      armed <= 1'b1;
      idx   <= '0;
    end else if (take) begin
      idx <= idx + CNT_W'(1);
      if (hit_end || short_end) armed <= 1'b0;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (idx <= CNT_W'(LAST_IDX))); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    take |=> (idx == $past(idx) + CNT_W'(1))); // R3
endmodule

// File: rtl/hrs_field_tap.sv
module hrs_field_tap #(
  parameter int DATA_W = 32,
  parameter int TAP_IDX = 69,
  parameter int LSB = 2,
  parameter int FW = 2,
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [CNT_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  output logic              flag
);
  logic [FW-1:0] field;
  logic          hit;
  logic          value;

  assign field = data[LSB +: FW];
  assign hit   = take && (idx == CNT_W'(TAP_IDX));

  generate
    if (ACTIVE_LOW) begin : g_low
      assign value = ~(&field);
    end else begin : g_high
      assign value = |field;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) flag <= 1'b0;
    else if (hit)     flag <= value;
  end

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !hit) |=> $stable(flag)); // R10
endmodule

// File: rtl/hrs_ratio_enc.sv
module hrs_ratio_enc
  import hdr_ratio_pkg::*;
(
  input  logic       enc,
  input  logic       cmp,
  input  logic       wide,
  output logic [1:0] code
);
  ratio_e base;

  always_comb begin
    if (cmp)      base = RATIO_X4;
    else if (enc) base = RATIO_X2;
    else          base = RATIO_X1;
    if (base != RATIO_X1 && wide) code = 2'(base) + 2'd1;
    else                          code = 2'(base);
  end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel #(
  parameter int DATA_W = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              enc_flag,
  output logic              cmp_flag,
  output logic [1:0]        ratio_code,
  output logic              done,
  output logic              len_err
);
  localparam int LAST_IDX = CMP_IDX;
  localparam int CNT_W = $clog2(LAST_IDX + 2);

  logic [CNT_W-1:0] idx;
  logic take, hit_end, short_end;
  logic wide_q;

  assign in_ready = 1'b1;

  hrs_word_counter #(.LAST_IDX(LAST_IDX)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_last(in_last), .idx(idx), .take(take), .hit_end(hit_end),
    .short_end(short_end)
  );

  hrs_field_tap #(.DATA_W(DATA_W), .TAP_IDX(ENC_IDX), .LSB(ENC_LSB),
    .FW(ENC_W), .ACTIVE_LOW(1'b0), .CNT_W(CNT_W)) u_enc (
    .clk(clk), .rst(rst), .clear(start), .take(take), .idx(idx),
    .data(in_data), .flag(enc_flag)
  );

  hrs_field_tap #(.DATA_W(DATA_W), .TAP_IDX(CMP_IDX), .LSB(CMP_BIT),
    .FW(1), .ACTIVE_LOW(1'b1), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(start), .take(take), .idx(idx),
    .data(in_data), .flag(cmp_flag)
  );

  hrs_ratio_enc u_enc_ratio (
    .enc(enc_flag), .cmp(cmp_flag), .wide(wide_q), .code(ratio_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q  <= 1'b0;
      done    <= 1'b0;
      len_err <= 1'b0;
    end else begin
      done <= hit_end;
      if (start) begin
        wide_q  <= wide_mode;
        len_err <= 1'b0;
      end else if (short_end) begin
        len_err <= 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !done); // R9
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    start |=> (!len_err && !done)); // R2
  AST_X1_CODE: assert property (@(posedge clk) disable iff (rst)
    (done && !enc_flag && !cmp_flag) |-> (ratio_code == 2'd0)); // R6
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(wide_q)); // R11
endmodule

// File: tb/tb_hdr_ratio_sel.sv
module tb_hdr_ratio_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wide_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_ready, enc_flag, cmp_flag, done, len_err;
  logic [1:0] ratio_code;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hdr_ratio_sel dut (
    .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .enc_flag(enc_flag), .cmp_flag(cmp_flag),
    .ratio_code(ratio_code), .done(done), .len_err(len_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_ratio(input bit e, input bit c, input bit w);
    int r;
    if (!e && !c) return 0;
    r = c ? 2 : 1;
    return r + (w ? 1 : 0);
  endfunction

  // non-header words carry encryption bits set and compression bit low
  function automatic logic [31:0] word_of(input int i, input logic [1:0] ev, input logic cb);
    logic [31:0] w;
    w = {i[15:0], 8'h5A, 8'h0C};
    if (i == 69)  w[3:2] = ev;
    if (i == 229) w[1] = cb;
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start(input bit w);
    @(negedge clk);
    start = 1'b1; wide_mode = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  // sends n words (last on n-1); records where done was seen
  task automatic run_stream(input int n, input logic [1:0] ev, input logic cb,
                            input int gap, output int done_at, output int done_cnt);
    done_at = -1; done_cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b1; in_data = 32'hFFFF_FFF1;
        @(posedge clk); #1;
        if (done) done_cnt++;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = word_of(i, ev, cb); in_last = (i == n - 1);
      @(posedge clk); #1;
      if (done) begin done_cnt++; done_at = i; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(posedge clk); #1;
    if (done) done_cnt++;
  endtask

  task automatic t_reset_state();
    chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
    chk(done == 1'b0 && len_err == 1'b0, "R12 done/err after reset", {done, len_err}, 0);
    chk(enc_flag == 1'b0 && cmp_flag == 1'b0 && ratio_code == 2'd0,
        "R12 flags after reset", {enc_flag, cmp_flag, ratio_code}, 0);
  endtask

  task automatic t_case(input bit w, input logic [1:0] ev, input logic cb, input int gap);
    int da, dc;
    bit e, c;
    e = (ev != 2'b00); c = ~cb;
    pulse_start(w);
    run_stream(230, ev, cb, gap, da, dc);
    chk(dc == 1 && da == 229, "R8 done once at word 229", da, 229);
    chk(enc_flag == e, "R4 enc flag", enc_flag, e);
    chk(cmp_flag == c, "R5 cmp flag", cmp_flag, c);
    chk(ratio_code == exp_ratio(e, c, w),
        w ? "R7 ratio at 32-bit" : "R6 ratio at 16-bit", ratio_code, exp_ratio(e, c, w));
    chk(len_err == 1'b0, "R9 no error on full stream", len_err, 0);
    chk(in_ready == 1'b1, "R1 ready after stream", in_ready, 1);
  endtask

  task automatic t_short();
    int da, dc;
    pulse_start(1'b1);
    run_stream(229, 2'b01, 1'b1, 0, da, dc);
    chk(len_err == 1'b1, "R9 error at 229 words", len_err, 1);
    chk(dc == 0, "R9 no done on short stream", dc, 0);
    pulse_start(1'b1);
    chk(len_err == 1'b0, "R2 start clears error", len_err, 0);
    run_stream(1, 2'b00, 1'b1, 0, da, dc);
    chk(len_err == 1'b1 && dc == 0, "R9 error on single word", len_err, 1);
  endtask

  task automatic t_tail();
    int da, dc;
    pulse_start(1'b0);
    run_stream(260, 2'b00, 1'b1, 0, da, dc);
    chk(dc == 1 && da == 229, "R10 single done with tail", dc, 1);
    chk(cmp_flag == 1'b0 && enc_flag == 1'b0, "R10 tail words ignored", {enc_flag, cmp_flag}, 0);
    chk(len_err == 1'b0, "R10 tail last raises no error", len_err, 0);
  endtask

  task automatic t_width_latch();
    int da, dc;
    pulse_start(1'b0);
    wide_mode = 1'b1;
    run_stream(230, 2'b10, 1'b1, 0, da, dc);
    chk(ratio_code == 2'd1, "R11 width latched at start", ratio_code, 1);
    wide_mode = 1'b0;
  endtask

  task automatic t_prestart();
    int da, dc;
    do_reset();
    run_stream(240, 2'b00, 1'b1, 0, da, dc);
    chk(dc == 0 && len_err == 1'b0, "R3 words before start ignored", dc, 0);
    chk(enc_flag == 1'b0 && cmp_flag == 1'b0, "R3 no capture before start",
        {enc_flag, cmp_flag}, 0);
  endtask

  task automatic t_restart();
    int da, dc;
    pulse_start(1'b0);
    run_stream(100, 2'b00, 1'b1, 0, da, dc);
    chk(len_err == 1'b1, "R9 partial run errors", len_err, 1);
    pulse_start(1'b1);
    run_stream(230, 2'b00, 1'b1, 0, da, dc);
    chk(dc == 1 && da == 229 && len_err == 1'b0, "R2 restart counts from 0", da, 229);
    chk(ratio_code == 2'd0, "R6 x1 at 32-bit", ratio_code, 0);
  endtask

  task automatic t_start_priority();
    int da, dc;
    @(negedge clk);
    start = 1'b1; wide_mode = 1'b0; in_valid = 1'b1; in_data = word_of(0, 2'b11, 1'b0);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    run_stream(230, 2'b00, 1'b1, 0, da, dc);
    chk(da == 229 && dc == 1, "R2 start-cycle word not counted", da, 229);
    chk(enc_flag == 1'b0 && cmp_flag == 1'b0, "R2 indices not shifted",
        {enc_flag, cmp_flag}, 0);
  endtask

  task automatic t_reset_clear();
    int da, dc;
    pulse_start(1'b1);
    run_stream(230, 2'b11, 1'b0, 0, da, dc);
    chk(ratio_code == 2'd3, "R7 enc+cmp at 32-bit", ratio_code, 3);
    do_reset();
    #1;
    chk(enc_flag == 1'b0 && cmp_flag == 1'b0 && ratio_code == 2'd0,
        "R12 reset clears result", ratio_code, 0);
    run_stream(230, 2'b11, 1'b0, 0, da, dc);
    chk(dc == 0 && enc_flag == 1'b0, "R12 disarmed after reset", dc, 0);
  endtask

  initial begin
    do_reset();
    #1;
    t_reset_state();
    t_case(1'b0, 2'b00, 1'b1, 0);
    t_case(1'b1, 2'b00, 1'b1, 0);
    t_case(1'b0, 2'b01, 1'b1, 0);
    t_case(1'b0, 2'b10, 1'b0, 0);
    t_case(1'b0, 2'b00, 1'b0, 0);
    t_case(1'b1, 2'b11, 1'b1, 0);
    t_case(1'b1, 2'b00, 1'b0, 3);
    t_case(1'b1, 2'b10, 1'b0, 0);
    t_short();
    t_tail();
    t_width_latch();
    t_restart();
    t_start_priority();
    t_reset_clear();
    t_prestart();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule